// File: doc/BRIEF.md
# Two-Address Memory-to-Memory Processor

This block is a small multicycle stored-program processor. Code and data share one word-addressed memory of 16-bit words. The control unit keeps a program counter and instruction registers. It reads each instruction as three memory words, decodes it and executes it against memory. It then steps the program counter and repeats the cycle until it meets a halt. Arithmetic reads both operands from memory and writes the result back over the first operand. A compare instruction sets an equality flag, and a conditional jump tests that flag.

A test environment holds the processor in reset, fills memory through a write port, and sets the start address. It then releases reset and waits for `halted`. After that it reads results back through the same port. An ALU instruction takes five cycles, a jump takes four, and a halt takes four before `halted` rises.

Top module: `mm_cpu`

## Requirements
- R1: While `rst` is high the program counter loads `start_addr`, the equality flag clears to 0 and `halted` is low. A jump conditioned on the flag that runs first after reset is therefore not taken.
- R2: An instruction is three consecutive words. Bits [7:0] of the first word hold the opcode and its bits [15:8] are ignored. The second word holds the first address and the third holds the second address. After a non-jump instruction the program counter advances by 3.
- R3: Opcode 9 (add) stores mem[first] + mem[second], modulo 2^16, at the first address.
- R4: Opcode 10 (subtract) stores mem[first] - mem[second], modulo 2^16, at the first address.
- R5: Opcode 11 (compare) sets the flag to 1 when mem[first] equals mem[second] and clears it to 0 otherwise. It writes no memory.
- R6: Opcode 12 (jump if equal) loads the program counter with the first address when the flag is 1. When the flag is 0 it advances by 3. It writes no memory.
- R7: Opcode 0 (halt) raises `halted` four cycles after its fetch begins. `halted` then stays high and memory is not written until the next reset.
- R8: Any opcode other than 0, 9, 10, 11 and 12 behaves as a halt.
- R9: `tb_we` writes `tb_wdata` at `tb_addr` only while `rst` is high. While `rst` is low it has no effect.
- R10: `tb_rdata` always shows the memory word at `tb_addr`, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | 16 | Address of the first instruction |
| halted | output | 1 | High once a halt has executed |
| tb_we | input | 1 | Preload write enable, honoured only in reset |
| tb_addr | input | 16 | Preload / inspect address |
| tb_wdata | input | 16 | Preload write data |
| tb_rdata | output | 16 | Memory word at `tb_addr` |

## Verification
The bench runs programs that start at a nonzero address. It drives sums and differences across the 16-bit wrap. A design that carried or borrowed into extra bits, or wrote the result to the second address, would leave a wrong word in memory. The bench also runs a taken jump and a fall-through jump. It places a compare that must not write memory, and an opcode word whose upper byte is nonzero. A decoder that read too many bits, or a flag that survived reset, would execute skipped code or skip live code. It also counts cycles to `halted`, pokes the write port after the halt, and runs an undefined opcode. An extra or missing state, a leaky write enable, or a decoder that ran unknown opcodes would show up as a wrong cycle count or a changed word.

// File: rtl/mm_cpu.sv
module mm_cpu #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 16,
  parameter int OP_W      = 8,
  parameter int MEM_DEPTH = 256,
  parameter int PC_STEP   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              halted,
  input  logic              tb_we,
  input  logic [ADDR_W-1:0] tb_addr,
  input  logic [DATA_W-1:0] tb_wdata,
  output logic [DATA_W-1:0] tb_rdata
);
  localparam int IDX_W = $clog2(MEM_DEPTH);
  localparam logic [OP_W-1:0] OP_HALT = OP_W'(0);
  localparam logic [OP_W-1:0] OP_ADD  = OP_W'(9);
  localparam logic [OP_W-1:0] OP_SUB  = OP_W'(10);
  localparam logic [OP_W-1:0] OP_CMP  = OP_W'(11);
  localparam logic [OP_W-1:0] OP_JEQ  = OP_W'(12);

  typedef enum logic [2:0] {S_F0, S_F1, S_F2, S_DEC, S_EX, S_HALT} state_t;

  state_t            state;
  logic [ADDR_W-1:0] pc, ir_a, ir_b, rd_addr;
  logic [OP_W-1:0]   op;
  logic [DATA_W-1:0] mem [MEM_DEPTH];
  logic [DATA_W-1:0] rd, opa, result;
  logic              eq, mem_we, op_known;

  always_comb begin
    case (state)
      S_F1:    rd_addr = pc + ADDR_W'(1);
      S_F2:    rd_addr = pc + ADDR_W'(2);
      S_DEC:   rd_addr = ir_a;
      S_EX:    rd_addr = ir_b;
      default: rd_addr = pc;
    endcase
  end

  assign rd       = mem[rd_addr[IDX_W-1:0]];
  assign tb_rdata = mem[tb_addr[IDX_W-1:0]];
  assign result   = (op == OP_SUB) ? opa - rd : opa + rd;
  assign mem_we   = (state == S_EX) && (op == OP_ADD || op == OP_SUB);
  assign op_known = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP) || (op == OP_JEQ);
  assign halted   = (state == S_HALT);

  logic unused_hi;
  assign unused_hi = ^{rd_addr[ADDR_W-1:IDX_W], tb_addr[ADDR_W-1:IDX_W], ir_b[ADDR_W-1:IDX_W]};

  always_ff @(posedge clk) begin
    if (rst && tb_we)
      mem[tb_addr[IDX_W-1:0]] <= tb_wdata;
    else if (mem_we)
      mem[ir_a[IDX_W-1:0]] <= result;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_F0;
      pc    <= start_addr;
      eq    <= 1'b0;
      op    <= OP_HALT;
      ir_a  <= '0;
      ir_b  <= '0;
      opa   <= '0;
    end else begin
      case (state)
        S_F0: begin op <= rd[OP_W-1:0]; state <= S_F1; end
        S_F1: begin ir_a <= ADDR_W'(rd); state <= S_F2; end
        S_F2: begin ir_b <= ADDR_W'(rd); state <= S_DEC; end
        S_DEC: begin
          if (!op_known) state <= S_HALT;
          else if (op == OP_JEQ) begin
            pc    <= eq ? ir_a : pc + ADDR_W'(PC_STEP);
            state <= S_F0;
          end else begin
            opa   <= rd;
            state <= S_EX;
          end
        end
        S_EX: begin
          if (op == OP_CMP) eq <= (opa == rd);
          pc    <= pc + ADDR_W'(PC_STEP);
          state <= S_F0;
        end
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/mm_cpu_chk.sv
module mm_cpu_chk #(
  parameter int ADDR_W = 16,
  parameter int OP_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              halted,
  input logic              mem_we,
  input logic [2:0]        state,
  input logic [OP_W-1:0]   op,
  input logic              eq,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] ir_a,
  input logic [ADDR_W-1:0] start_addr
);
  localparam logic [2:0] ST_DEC = 3'd3;
  localparam logic [2:0] ST_EX  = 3'd4;

  // R1
  pc_start_chk: assert property (@(posedge clk) rst |=> pc == $past(start_addr));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_EX |=> pc == $past(pc) + ADDR_W'(3));

  // R6
  jeq_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEC && op == OP_W'(12) && eq) |=> pc == $past(ir_a));

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R7
  halt_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  // R5
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EX && op == OP_W'(11)) |-> !mem_we);
endmodule

bind mm_cpu mm_cpu_chk #(.ADDR_W(ADDR_W), .OP_W(OP_W)) chk_i (
  .clk(clk), .rst(rst), .halted(halted), .mem_we(mem_we), .state(state),
  .op(op), .eq(eq), .pc(pc), .ir_a(ir_a), .start_addr(start_addr)
);

// File: tb/mm_cpu_tb_top.sv
module mm_cpu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] start_addr = '0;
  logic        halted;
  logic        tb_we = 1'b0;
  logic [15:0] tb_addr = '0;
  logic [15:0] tb_wdata = '0;
  logic [15:0] tb_rdata;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [15:0] addr; logic [15:0] data; string req; } exp_t;
  exp_t exp_q[$];
  event chk_ev;
  bit   mon_busy = 1'b0;

  always #5 clk = ~clk;

  mm_cpu dut_i (
    .clk(clk), .rst(rst), .start_addr(start_addr), .halted(halted),
    .tb_we(tb_we), .tb_addr(tb_addr), .tb_wdata(tb_wdata), .tb_rdata(tb_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_mem(input logic [15:0] a, input logic [15:0] d, input string req);
    exp_t e;
    e.addr = a; e.data = d; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic flush();
    mon_busy = 1'b1;
    -> chk_ev;
    wait (mon_busy == 1'b0);
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        tb_addr = e.addr;
        #1;
        check(e.req, {16'h0, tb_rdata}, {16'h0, e.data});
      end
      mon_busy = 1'b0;
    end
  end

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = a; tb_wdata = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic instr(input logic [15:0] at, input logic [15:0] w0,
                       input logic [15:0] a, input logic [15:0] b);
    wr(at, w0);
    wr(at + 16'd1, a);
    wr(at + 16'd2, b);
  endtask

  task automatic run(output int n);
    @(negedge clk);
    rst = 1'b0;
    check("R1 halted low after reset", {31'h0, halted}, 32'h0);
    n = 0;
    while (!halted && n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected halt");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // program 1 at 0x10
    @(negedge clk);
    rst = 1'b1;
    start_addr = 16'h0010;
    wr(100, 16'd5);  wr(101, 16'd7);
    wr(102, 16'd3);  wr(103, 16'd5);
    wr(104, 16'hFFFF); wr(105, 16'd2);
    wr(106, 16'd12); wr(107, 16'd21); wr(108, 16'd1);
    instr(16, 16'd9,  100, 101);
    instr(19, 16'd10, 102, 103);
    instr(22, 16'd9,  104, 105);
    instr(25, 16'd11, 100, 106);
    instr(28, 16'd12, 40, 0);
    instr(31, 16'd0,  0, 0);
    instr(40, 16'd11, 100, 101);
    instr(43, 16'd12, 50, 0);
    instr(46, 16'h3709, 107, 107);
    instr(49, 16'd0,  0, 0);
    instr(50, 16'd9,  108, 108);
    run(n);
    // 6 ALU x5 + 2 JEQ x4 + HALT 4 = 42
    check("R2 R7 cycles to halted", n, 42);
    expect_mem(100, 16'd12,   "R3 add");
    expect_mem(102, 16'hFFFE, "R4 sub wrap");
    expect_mem(104, 16'h0001, "R3 add wrap");
    expect_mem(106, 16'd12,   "R5 compare leaves memory");
    expect_mem(101, 16'd7,    "R5 compare leaves memory");
    expect_mem(107, 16'd42,   "R2 opcode upper byte ignored");
    expect_mem(108, 16'd1,    "R6 fall-through and taken jumps");
    flush();
    // R9: write port ignored while running
    @(negedge clk);
    tb_we = 1'b1; tb_addr = 100; tb_wdata = 16'hAAAA;
    @(negedge clk);
    tb_we = 1'b0;
    repeat (20) @(negedge clk);
    check("R7 halted stays high", {31'h0, halted}, 32'h1);
    expect_mem(100, 16'd12, "R9 write ignored out of reset");
    expect_mem(103, 16'd5,  "R7 no memory writes when halted");
    flush();

    // program 2: set flag, then reset must clear it
    rst = 1'b1;
    start_addr = 16'h0000;
    wr(60, 16'd4); wr(61, 16'd4);
    instr(0, 16'd11, 60, 61);
    instr(3, 16'd0, 0, 0);
    run(n);
    check("R5 R7 cmp then halt cycles", n, 9);
    @(negedge clk);
    rst = 1'b1;
    instr(0, 16'd12, 20, 0);
    instr(3, 16'd9, 61, 61);
    instr(6, 16'd0, 0, 0);
    instr(20, 16'd0, 0, 0);
    run(n);
    check("R1 flag cleared by reset cycles", n, 13);
    expect_mem(61, 16'd8, "R1 jump not taken after reset");
    expect_mem(60, 16'd4, "R5 compare operand kept");
    flush();

    // program 3: undefined opcode
    @(negedge clk);
    rst = 1'b1;
    start_addr = 16'h0080;
    wr(62, 16'd3);
    instr(16'h80, 16'h0055, 62, 62);
    instr(16'h83, 16'd9, 62, 62);
    run(n);
    check("R8 undefined opcode halts", n, 4);
    expect_mem(62, 16'd3, "R8 no execution after undefined opcode");
    expect_mem(16'h0180, 16'h0055, "R10 read port wraps to memory depth");
    flush();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule